// File: doc/BRIEF.md
# PHY Management Bus Master

This block is a register-driven master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). A host writes a small set of registers through a flat port, one write per clock: a setup word holding the clock divider and an enable, a command word, a write-data word, and a read-result word. A command write with the initiate bit set makes the block shift out one clause-22 management frame and report completion through a ready flag in the command word.

The frame is 64 MDC periods long: 32 preamble ones, the start pattern 01, the opcode, the 5-bit PHY address, the 5-bit register address, the two turnaround bits and 16 data bits, always MSB first. On a read, the block stops driving MDIO from the first turnaround bit to the end of the frame and captures the PHY's answer on each rising MDC edge. MDIO leaves the block as a data bit and an output enable, which a pad combines into the tri-state line. While no frame is in flight MDC stays low and MDIO is released.

Top module: `mdio_master`

## Requirements
- R1: After reset the command word reads 0x0000_0080 (ready high), the setup word reads 29 (divider 29, enable clear), MDC is low and the MDIO output enable is low.
- R2: Register addresses are 0 setup (divider in bits 5:0, enable in bit 6), 1 command, 2 write data (bits 15:0), 3 read result (bits 15:0). The command word reads back PHY address in bits 28:24, register address in bits 20:16, the read select in bit 15, the write select in bit 14, ready in bit 7, and the initiate bit 11 as zero.
- R3: A command write with bit 11 set, bit 15 or bit 14 set, the enable set and ready high starts a frame, and ready reads low from the next cycle on; with both select bits set the frame is a read.
- R4: With the enable clear, an initiate is ignored: ready stays high and MDC stays low.
- R5: During a frame each MDC half period lasts divider+1 clocks, so rising MDC edges are 2·(divider+1) clocks apart; outside a frame MDC is low.
- R6: A frame carries 32 ones, then 01, then opcode 10 for read or 01 for write, the PHY address, the register address, then for a write the turnaround 10 and the 16 write-data bits; a write frame drives MDIO for all 64 bits.
- R7: On a read the output enable is low from the first turnaround bit to the end of the frame, MDIO is sampled on rising MDC, and the 16 sampled bits appear in the read-result word when ready returns high.
- R8: Ready returns high exactly 128·(divider+1) clocks after the clock edge that accepted the initiate.
- R9: A command write while a frame is in flight is ignored: the frame in flight, its result and the command fields read back are unchanged.
- R10: A read of a PHY address that nobody answers, with MDIO pulled high, returns 0xFFFF.
- R11: A command write with bit 11 set but neither select bit set starts nothing: ready stays high and MDC stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable, high while the block drives |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The assertions watch the bus handshake on every cycle: ready falls after an accepted initiate and returns after the last bit, no frame starts while the enable is clear, MDC moves only on divider ticks and rests low when idle, a write frame drives MDIO throughout, and a read frame, once it lets go of MDIO, does not take it back. Only the bench scenarios can show the frame contents bit by bit, the exact frame length in clocks, the MDC period at a given divider, and the data path through a modelled PHY, including the all-ones result from an unpopulated address and the ignored second command during a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_HI_BIT  = 17;   // first turnaround bit index in the frame
  localparam int DATA_BITS  = 16;

  // command word field positions
  localparam int CMD_PHY_LSB = 24;
  localparam int CMD_REG_LSB = 16;
  localparam int CMD_RD_BIT  = 15;
  localparam int CMD_WR_BIT  = 14;
  localparam int CMD_GO_BIT  = 11;
  localparam int CMD_RDY_BIT = 7;
  localparam int SETUP_EN_BIT = 6;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  // read select wins over write select
  function automatic mdio_op_e pick_op(input logic rd_sel, input logic wr_sel);
    if (rd_sel)      return OP_READ;
    else if (wr_sel) return OP_WRITE;
    else             return OP_NONE;
  endfunction

  // full 64-bit frame image, bit 63 goes out first
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input mdio_op_e          op,
    input logic [4:0]        phy,
    input logic [4:0]        regad,
    input logic [DATA_BITS-1:0] wdat
  );
    logic [1:0]  ta;
    logic [15:0] body;
    ta   = (op == OP_READ) ? 2'b11 : 2'b10;
    body = (op == OP_READ) ? 16'hFFFF : wdat;
    return {32'hFFFF_FFFF, 2'b01, logic'(op[1]), logic'(op[0]), phy, regad, ta, body};
  endfunction

  // clocks per MDC half period
  function automatic int half_clocks(input int divider);
    return divider + 1;
  endfunction

endpackage

// File: rtl/mdio_host_regs.sv
module mdio_host_regs #(
  parameter int DIV_W     = 6,
  parameter int DIV_RESET = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             busy,
  input  logic [15:0]      rd_result,
  output logic             start,
  output mdio_pkg::mdio_op_e op,
  output logic [4:0]       phy,
  output logic [4:0]       regad,
  output logic [15:0]      wdat,
  output logic [DIV_W-1:0] div,
  output logic             en
);
  import mdio_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic             en_q;
  logic [4:0]       phy_q, reg_q;
  logic             rdsel_q, wrsel_q;
  logic [15:0]      wdat_q;
  logic             cmd_wr;
  mdio_op_e         op_req;
  logic             unused_bits;

  assign cmd_wr = wr_en && (addr == 2'd1);
  assign op_req = pick_op(wdata[CMD_RD_BIT], wdata[CMD_WR_BIT]);
  assign start  = cmd_wr && wdata[CMD_GO_BIT] && en_q && !busy && (op_req != OP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(DIV_RESET);
      en_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      rdsel_q <= 1'b0;
      wrsel_q <= 1'b0;
      wdat_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: begin
          div_q <= wdata[DIV_W-1:0];
          en_q  <= wdata[SETUP_EN_BIT];
        end
        2'd1: if (!busy) begin
          phy_q   <= wdata[CMD_PHY_LSB +: 5];
          reg_q   <= wdata[CMD_REG_LSB +: 5];
          rdsel_q <= wdata[CMD_RD_BIT];
          wrsel_q <= wdata[CMD_WR_BIT];
        end
        2'd2: wdat_q <= wdata[15:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: begin
        rdata[DIV_W-1:0]    = div_q;
        rdata[SETUP_EN_BIT] = en_q;
      end
      2'd1: begin
        rdata[CMD_PHY_LSB +: 5] = phy_q;
        rdata[CMD_REG_LSB +: 5] = reg_q;
        rdata[CMD_RD_BIT]       = rdsel_q;
        rdata[CMD_WR_BIT]       = wrsel_q;
        rdata[CMD_RDY_BIT]      = !busy;
      end
      2'd2:    rdata[15:0] = wdat_q;
      default: rdata[15:0] = rd_result;
    endcase
  end

  // frame fields come straight from the accepting write
  assign op    = op_req;
  assign phy   = wdata[CMD_PHY_LSB +: 5];
  assign regad = wdata[CMD_REG_LSB +: 5];
  assign wdat  = wdat_q;
  assign div   = div_q;
  assign en    = en_q;

  assign unused_bits = ^{wdata[31:29], wdata[23:21], wdata[13:12], wdata[10:7], wdata[5:0]};

endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick = run && (cnt_q == div);
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;
  assign mdc  = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_pkg::mdio_op_e op,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdat,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        busy,
  output logic        is_read,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_result
);
  import mdio_pkg::*;

  logic                  busy_q, rd_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic [15:0]           shr_q, res_q;
  logic                  released, in_data;

  assign released = rd_q && (idx_q <= IDX_W'(TA_HI_BIT));
  assign in_data  = idx_q < IDX_W'(DATA_BITS);
  assign done     = busy_q && fall && (idx_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      frame_q <= '0;
      idx_q   <= '0;
      shr_q   <= '0;
      res_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      rd_q    <= (op == OP_READ);
      frame_q <= build_frame(op, phy, regad, wdat);
      idx_q   <= IDX_W'(FRAME_BITS - 1);
    end else if (busy_q) begin
      if (rise && rd_q && in_data)
        shr_q <= {shr_q[14:0], mdio_i};
      if (done) begin
        busy_q <= 1'b0;
        if (rd_q) res_q <= shr_q;
      end else if (fall) begin
        idx_q <= idx_q - 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign is_read   = rd_q;
  assign mdio_o    = frame_q[idx_q];
  assign mdio_oe   = busy_q && !released;
  assign rd_result = res_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W     = 6,
  parameter int DIV_RESET = 29
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  // named internal events, observed by the bound checker
  logic             start_evt, done_evt, rise_evt, fall_evt;
  logic             busy, is_read, en;
  mdio_op_e         op;
  logic [4:0]       phy, regad;
  logic [15:0]      wdat, rd_result;
  logic [DIV_W-1:0] div;

  mdio_host_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .busy(busy), .rd_result(rd_result),
    .start(start_evt), .op(op), .phy(phy), .regad(regad), .wdat(wdat),
    .div(div), .en(en)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div),
    .mdc(mdc), .rise(rise_evt), .fall(fall_evt)
  );

  mdio_frame_seq i_seq (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .op(op), .phy(phy),
    .regad(regad), .wdat(wdat), .rise(rise_evt), .fall(fall_evt),
    .mdio_i(mdio_i), .busy(busy), .is_read(is_read), .done(done_evt),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_result(rd_result)
  );

endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic done_evt,
  input logic rise_evt,
  input logic fall_evt,
  input logic busy,
  input logic is_read,
  input logic en,
  input logic mdc,
  input logic mdio_oe
);

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy); // R3

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !start_evt); // R4

  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R5

  AST_MDC_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt || fall_evt) |=> $stable(mdc)); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy); // R1

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_read) |-> mdio_oe); // R6

  AST_STAYS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_read && !mdio_oe) |=> (!mdio_oe || !busy)); // R7

  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy); // R8

endmodule

bind mdio_master mdio_master_checker i_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .done_evt(done_evt),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .busy(busy), .is_read(is_read),
  .en(en), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;

  localparam logic [4:0] POP_PHY = 5'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 1'b0;
  logic [1:0]  h_addr = 2'd0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .host_wr(h_wr), .host_addr(h_addr),
    .host_wdata(h_wdata), .host_rdata(h_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model ----------------
  logic [15:0] phy_mem [32];
  logic [63:0] cap;
  int          pcnt;
  logic [1:0]  p_op;
  logic [4:0]  p_phy, p_reg;
  logic        p_drv, p_val;

  assign mdio_i = p_drv ? p_val : (mdio_oe ? mdio_o : 1'b1);

  initial begin
    for (int r = 0; r < 32; r++) phy_mem[r] = 16'hA000 ^ (16'(r) * 16'h0111);
    cap = '0; pcnt = 0; p_op = 2'b00; p_phy = '0; p_reg = '0;
    p_drv = 1'b0; p_val = 1'b0;
  end

  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_i};
    pcnt = pcnt + 1;
    if (pcnt == 46) begin
      p_op  = cap[11:10];
      p_phy = cap[9:5];
      p_reg = cap[4:0];
    end
    if (pcnt == 64 && p_op == 2'b01 && p_phy == POP_PHY)
      phy_mem[p_reg] = cap[15:0];
  end

  always @(negedge mdc) begin
    if (p_op == 2'b10 && p_phy == POP_PHY && pcnt >= 47 && pcnt <= 63) begin
      p_drv = 1'b1;
      p_val = (pcnt == 47) ? 1'b0 : phy_mem[p_reg][63 - pcnt];
    end else begin
      p_drv = 1'b0;
    end
  end

  // ---------------- helpers ----------------
  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [31:0] d);
    h_addr = a;
    #0.5;
    d = h_rdata;
  endtask

  function automatic logic [31:0] cmd(input logic rd, input logic wr, input logic [4:0] phy,
                                      input logic [4:0] rg);
    return (32'(phy) << 24) | (32'(rg) << 16) | (32'(rd) << 15) | (32'(wr) << 14) | 32'h800;
  endfunction

  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] f;
    f[63:32] = '1;
    f[31:30] = 2'b01;
    f[29:28] = op;
    f[27:23] = phy;
    f[22:18] = rg;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  // issue a command and count the low-ready samples until ready returns
  task automatic run_cmd(input logic [31:0] c, input string req, output int lows);
    logic [31:0] r;
    pcnt = 0; p_op = 2'b00;
    host_write(2'd1, c);
    host_read(2'd1, r);
    chk(r[7] == 1'b0, {req, " ready low after initiate (R3)"}, 64'(r[7]), 64'd0);
    lows = 0;
    while (!r[7] && lows < 20000) begin
      lows++;
      @(negedge clk);
      host_read(2'd1, r);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] r;
    host_read(2'd1, r); chk(r == 32'h80, "R1 command word", 64'(r), 64'h80);
    host_read(2'd0, r); chk(r == 32'd29, "R1 setup word", 64'(r), 64'd29);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 bus idle", {62'd0, mdc, mdio_oe}, 64'd0);
    host_write(2'd2, 32'h1234_ABCD);
    host_read(2'd2, r); chk(r == 32'h0000_ABCD, "R2 write-data readback", 64'(r), 64'hABCD);
  endtask

  task automatic t_disabled();
    logic [31:0] r;
    pcnt = 0;
    host_write(2'd1, cmd(1'b1, 1'b0, POP_PHY, 5'd3));
    host_read(2'd1, r); chk(r[7] == 1'b1, "R4 ready stays high", 64'(r[7]), 64'd1);
    repeat (20) @(negedge clk);
    chk(mdc == 1'b0 && pcnt == 0, "R4 mdc stays low", 64'(pcnt), 64'd0);
  endtask

  task automatic t_write(input logic [4:0] rg, input logic [15:0] d, input int dv);
    logic [31:0] r;
    int lows;
    host_write(2'd2, {16'd0, d});
    run_cmd(cmd(1'b0, 1'b1, POP_PHY, rg), "write", lows);
    chk(lows == 128 * (dv + 1), "R8 write frame length", 64'(lows), 64'(128 * (dv + 1)));
    chk(cap == exp_frame(2'b01, POP_PHY, rg, d), "R6 write frame bits", cap, exp_frame(2'b01, POP_PHY, rg, d));
    chk(phy_mem[rg] == d, "R6 PHY stored data", 64'(phy_mem[rg]), 64'(d));
    host_read(2'd1, r);
    chk(r == ((32'(POP_PHY) << 24) | (32'(rg) << 16) | 32'h4080), "R2 command readback",
        64'(r), 64'((32'(POP_PHY) << 24) | (32'(rg) << 16) | 32'h4080));
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic both,
                        input logic [15:0] want, input string req);
    logic [31:0] r;
    int lows;
    run_cmd(cmd(1'b1, both, phy, rg), req, lows);
    chk(lows == 256, {req, " R8 read frame length"}, 64'(lows), 64'd256);
    chk(cap[63:18] == exp_frame(2'b10, phy, rg, 16'd0) >> 18, {req, " R6 read header"},
        64'(cap[63:18]), exp_frame(2'b10, phy, rg, 16'd0) >> 18);
    chk(cap[17] == 1'b1, {req, " R7 turnaround released"}, 64'(cap[17]), 64'd1);
    host_read(2'd3, r);
    chk(r == {16'd0, want}, {req, " read result"}, 64'(r), 64'(want));
  endtask

  task automatic t_period();
    logic [31:0] r;
    time t1, t2;
    int lows;
    host_write(2'd0, 32'h43);
    host_read(2'd0, r); chk(r == 32'h43, "R2 setup readback", 64'(r), 64'h43);
    pcnt = 0; p_op = 2'b00;
    host_write(2'd1, cmd(1'b1, 1'b0, POP_PHY, 5'd7));
    @(posedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    chk((t2 - t1) == 32, "R5 MDC period at divider 3", 64'(t2 - t1), 64'd32);
    lows = 0;
    host_read(2'd1, r);
    while (!r[7] && lows < 20000) begin lows++; @(negedge clk); host_read(2'd1, r); end
    host_read(2'd3, r);
    chk(r[15:0] == phy_mem[7], "R7 read at divider 3", 64'(r), 64'(phy_mem[7]));
    host_write(2'd0, 32'h41);
  endtask

  task automatic t_busy_cmd();
    logic [31:0] r;
    int lows;
    pcnt = 0; p_op = 2'b00;
    host_write(2'd1, cmd(1'b1, 1'b0, POP_PHY, 5'd3));
    repeat (30) @(negedge clk);
    host_write(2'd1, cmd(1'b0, 1'b1, 5'd2, 5'd5));
    host_read(2'd1, r);
    chk(r[28:24] == POP_PHY && r[20:16] == 5'd3 && r[15:14] == 2'b10, "R9 fields unchanged",
        64'(r[31:8]), 64'((32'(POP_PHY) << 16) | (32'd3 << 8) | 32'h80) >> 0);
    lows = 0;
    while (!r[7] && lows < 20000) begin lows++; @(negedge clk); host_read(2'd1, r); end
    chk(cap[29:18] == {2'b10, POP_PHY, 5'd3}, "R9 frame in flight unchanged",
        64'(cap[29:18]), 64'({2'b10, POP_PHY, 5'd3}));
    host_read(2'd3, r);
    chk(r[15:0] == phy_mem[3], "R9 result unchanged", 64'(r), 64'(phy_mem[3]));
  endtask

  task automatic t_noop();
    logic [31:0] r;
    pcnt = 0;
    host_write(2'd1, 32'h0000_0800);
    host_read(2'd1, r); chk(r[7] == 1'b1, "R11 ready stays high", 64'(r[7]), 64'd1);
    repeat (10) @(negedge clk);
    chk(mdc == 1'b0 && pcnt == 0, "R11 no MDC activity", 64'(pcnt), 64'd0);
  endtask

  task automatic t_default_div();
    int lows;
    host_write(2'd0, 32'h40 | 32'd29);
    run_cmd(cmd(1'b1, 1'b0, POP_PHY, 5'd1), "div29", lows);
    chk(lows == 128 * 30, "R8 frame length at divider 29", 64'(lows), 64'(128 * 30));
    host_write(2'd0, 32'h41);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    host_write(2'd0, 32'h41);          // enable, divider 1
    t_write(5'd3, 16'hBEEF, 1);
    t_read(POP_PHY, 5'd3, 1'b0, 16'hBEEF, "R7 populated");
    t_read(POP_PHY, 5'd7, 1'b0, phy_mem[7], "R7 initial value");
    t_read(5'd2, 5'd3, 1'b0, 16'hFFFF, "R10 unpopulated");
    t_read(POP_PHY, 5'd3, 1'b1, 16'hBEEF, "R3 both selects");
    t_period();
    t_busy_cmd();
    t_noop();
    t_default_div();
    finish_run();
  end

endmodule